// File: doc/BRIEF.md
# Scanline and Vertical-Blank Interrupt Controller

This block produces the two raster interrupts of a video display processor: a line interrupt every few scanlines and a vertical-blank interrupt once per frame. A frame-start pulse opens each frame. A line strobe marks the start of every scanline after that. The block counts lines internally, so it knows where the active picture ends and blanking begins. The active picture is 224 lines tall, or 240 lines when the tall mode input is set.

A down-counter is loaded with a programmable interval at frame start. It steps once per active line and once more on the first blanking line. Each time it underflows it reloads and flags a line interrupt. When blanking begins, the vertical-blank status bit and the vertical pending flag are set at once. The level-6 request to the CPU follows only after a fixed number of CPU cycles, counted on a cycle-tick input. The CPU sees a single 3-bit request level, where level 6 outranks level 4. It retires a request by presenting the level on the acknowledge input, which clears the matching pending flag.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `scanline_irq_ctrl`

## Requirements
- R1: After reset, `status`, `pending` and `irq_level` are all zero. Line strobes are ignored until the first `frame_start`.
- R2: A `frame_start` loads the line counter from `line_reload` and restarts the line index at 0. It clears status bit 3 (vertical blank) and status bit 7 (vertical interrupt due) by the next cycle. If `frame_start` and `line_strobe` arrive together, `frame_start` wins.
- R3: With line index y counted from 0 after `frame_start`, the counter steps on every strobe with y <= A, where A is the active line count. A step that finds the counter at 0 reloads it from `line_reload` and sets pending bit 4. For interval N this flags lines N, 2N+1, and so on.
- R4: Strobes for lines y > A do not step the counter, so pending bit 4 is never set during the remaining blanking lines.
- R5: A is 224 when `tall_mode` is 0 and 240 when it is 1. Status bit 3 and pending bit 5 are set on the edge of the strobe for line A, and not on any earlier line.
- R6: Status bit 7 is set on the edge of the 68th `cpu_tick` after the line-A strobe edge. A tick in the same cycle as that strobe does not count. From then on, `irq_level` shows 6 while pending bit 5 and `vint_en` are both 1. With `vint_en` at 0, status bit 7 still sets but level 6 is never shown.
- R7: `irq_level` is 4 while pending bit 4 is set, `hint_en` is 1 and no level-6 request is active.
- R8: When the level-6 and level-4 requests are both active, `irq_level` is 6.
- R9: `ack_valid` with `ack_level` = 6 clears pending bit 5, and with `ack_level` = 4 clears pending bit 4, on that edge. `irq_level` then falls back to the other request, or to 0. A new flag set on the same edge takes precedence over the clear.
- R10: With `hint_en` at 0, pending bit 4 is still set on underflow, but `irq_level` stays at 0 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| line_strobe | input | 1 | One-cycle pulse at the start of each scanline |
| tall_mode | input | 1 | 1 selects 240 active lines, 0 selects 224 |
| line_reload | input | 8 | Line-interrupt interval reload value |
| hint_en | input | 1 | Line interrupt enable (mode register 0, bit 4) |
| vint_en | input | 1 | Vertical interrupt enable (mode register 1, bit 5) |
| cpu_tick | input | 1 | One CPU cycle has elapsed |
| ack_valid | input | 1 | CPU acknowledges the level on `ack_level` |
| ack_level | input | 3 | Level being acknowledged (4 or 6) |
| status | output | 8 | Bit 3 vertical blank, bit 7 vertical interrupt due, other bits 0 |
| pending | output | 8 | Bit 4 line interrupt pending, bit 5 vertical interrupt pending, other bits 0 |
| irq_level | output | 3 | Requested interrupt level: 0, 4 or 6 |

## Verification
A wrong line counter shows up as pending bit 4 on the wrong strobe. This is visible one cycle after that strobe, and it shifts every later line interrupt in the frame. A line index that stops or runs past the active area shows as status bit 3 rising on the wrong line, or as a line interrupt during blanking. Both are caught on the first line where they differ. A lag counter that is off by even one tick moves status bit 7 and level 6 by one tick. The bench compares them on ticks 67 and 68, so the error appears at once. Faults in acknowledge or priority show on `irq_level` in the cycle right after the acknowledge.

// File: rtl/lvi_pkg.sv
package lvi_pkg;
  // bit positions that software decodes
  localparam int STAT_VBLANK_BIT = 3;
  localparam int STAT_VDUE_BIT   = 7;
  localparam int PEND_HINT_BIT   = 4;
  localparam int PEND_VINT_BIT   = 5;

  // request levels
  localparam logic [2:0] LVL_NONE = 3'd0;
  localparam logic [2:0] LVL_HINT = 3'd4;
  localparam logic [2:0] LVL_VINT = 3'd6;
endpackage

// File: rtl/lvi_line_counter.sv
module lvi_line_counter #(
  parameter int CNT_W        = 8,
  parameter int ACTIVE_SHORT = 224,
  parameter int ACTIVE_TALL  = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_strobe,
  input  logic             tall_mode,
  input  logic [CNT_W-1:0] reload,
  output logic             hint_fire,
  output logic             vblank_start
);
  localparam int LINE_W = $clog2(ACTIVE_TALL + 2) + 1;
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_q;
  logic              armed_q;
  logic [LINE_W-1:0] active_lines;
  logic              line_ev;
  logic              step;

  assign active_lines = tall_mode ? LINE_W'(ACTIVE_TALL) : LINE_W'(ACTIVE_SHORT);
  assign line_ev      = line_strobe && armed_q && !frame_start;
  assign step         = line_ev && (line_q <= active_lines);
  assign hint_fire    = step && (cnt_q == '0);
  assign vblank_start = line_ev && (line_q == active_lines);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      line_q  <= '0;
      armed_q <= 1'b0;
    end else if (frame_start) begin
      cnt_q   <= reload;
      line_q  <= '0;
      armed_q <= 1'b1;
    end else if (line_ev) begin
      if (step) begin
        if (cnt_q == '0) cnt_q <= reload;
        else             cnt_q <= cnt_q - 1'b1;
      end
      if (line_q != LINE_MAX) line_q <= line_q + 1'b1;
    end
  end

  // underflow reloads the counter from the interval value
  p_reload_on_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hint_fire |=> (cnt_q == $past(reload)));

  // no counter activity before the first frame opens
  p_idle_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (!hint_fire && !vblank_start));

  // vertical blank begins exactly once per frame
  p_single_vblank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start |=> !vblank_start);
endmodule

// File: rtl/lvi_vblank_lag.sv
module lvi_vblank_lag #(
  parameter int LAG = 68
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic vblank_start,
  input  logic cpu_tick,
  output logic vblank,
  output logic vint_due
);
  localparam int LAG_W = $clog2(LAG + 1) + 1;

  logic [LAG_W-1:0] lag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank   <= 1'b0;
      vint_due <= 1'b0;
      lag_q    <= '0;
    end else if (frame_start) begin
      vblank   <= 1'b0;
      vint_due <= 1'b0;
      lag_q    <= '0;
    end else if (vblank_start) begin
      vblank   <= 1'b1;
      vint_due <= (LAG == 0);
      lag_q    <= LAG_W'(LAG);
    end else if (cpu_tick && (lag_q != '0)) begin
      lag_q <= lag_q - 1'b1;
      if (lag_q == LAG_W'(1)) vint_due <= 1'b1;
    end
  end

  // the vertical interrupt never precedes blanking
  p_due_inside_vblank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vint_due |-> vblank);

  p_lag_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lag_q <= LAG_W'(LAG));

  // the lag only runs while due is still outstanding
  p_lag_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vint_due && !vblank_start) |-> (lag_q == '0));
endmodule

// File: rtl/lvi_irq_arbiter.sv
module lvi_irq_arbiter
  import lvi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hint_fire,
  input  logic       vblank_start,
  input  logic       vint_due,
  input  logic       hint_en,
  input  logic       vint_en,
  input  logic       ack_valid,
  input  logic [2:0] ack_level,
  output logic       hint_pend,
  output logic       vint_pend,
  output logic [2:0] irq_level
);
  logic ack_hint;
  logic ack_vint;
  logic req_hint;
  logic req_vint;

  assign ack_hint = ack_valid && (ack_level == LVL_HINT);
  assign ack_vint = ack_valid && (ack_level == LVL_VINT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_pend <= 1'b0;
      vint_pend <= 1'b0;
    end else begin
      if (hint_fire)     hint_pend <= 1'b1;
      else if (ack_hint) hint_pend <= 1'b0;
      if (vblank_start)  vint_pend <= 1'b1;
      else if (ack_vint) vint_pend <= 1'b0;
    end
  end

  assign req_hint = hint_pend && hint_en;
  assign req_vint = vint_pend && vint_due && vint_en;

  always_comb begin
    if (req_vint)      irq_level = LVL_VINT;
    else if (req_hint) irq_level = LVL_HINT;
    else               irq_level = LVL_NONE;
  end

  p_ack_hint_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hint && !hint_fire) |=> !hint_pend);

  p_ack_vint_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vint && !vblank_start) |=> !vint_pend);

  p_fire_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hint_fire |=> hint_pend);

  p_level_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == LVL_NONE) || (irq_level == LVL_HINT) || (irq_level == LVL_VINT));
endmodule

// File: rtl/scanline_irq_ctrl.sv
module scanline_irq_ctrl
  import lvi_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int ACTIVE_SHORT = 224,
  parameter int ACTIVE_TALL  = 240,
  parameter int VINT_LAG     = 68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             line_strobe,
  input  logic             tall_mode,
  input  logic [CNT_W-1:0] line_reload,
  input  logic             hint_en,
  input  logic             vint_en,
  input  logic             cpu_tick,
  input  logic             ack_valid,
  input  logic [2:0]       ack_level,
  output logic [7:0]       status,
  output logic [7:0]       pending,
  output logic [2:0]       irq_level
);
  logic hint_fire;
  logic vblank_start;
  logic vblank;
  logic vint_due;
  logic hint_pend;
  logic vint_pend;

  lvi_line_counter #(
    .CNT_W        (CNT_W),
    .ACTIVE_SHORT (ACTIVE_SHORT),
    .ACTIVE_TALL  (ACTIVE_TALL)
  ) u_line_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .line_strobe  (line_strobe),
    .tall_mode    (tall_mode),
    .reload       (line_reload),
    .hint_fire    (hint_fire),
    .vblank_start (vblank_start)
  );

  lvi_vblank_lag #(
    .LAG (VINT_LAG)
  ) u_vblank_lag (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .vblank_start (vblank_start),
    .cpu_tick     (cpu_tick),
    .vblank       (vblank),
    .vint_due     (vint_due)
  );

  lvi_irq_arbiter u_irq_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .hint_fire    (hint_fire),
    .vblank_start (vblank_start),
    .vint_due     (vint_due),
    .hint_en      (hint_en),
    .vint_en      (vint_en),
    .ack_valid    (ack_valid),
    .ack_level    (ack_level),
    .hint_pend    (hint_pend),
    .vint_pend    (vint_pend),
    .irq_level    (irq_level)
  );

  always_comb begin
    status  = '0;
    pending = '0;
    status[STAT_VBLANK_BIT] = vblank;
    status[STAT_VDUE_BIT]   = vint_due;
    pending[PEND_HINT_BIT]  = hint_pend;
    pending[PEND_VINT_BIT]  = vint_pend;
  end

  p_vblank_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[STAT_VBLANK_BIT]) |-> pending[PEND_VINT_BIT]);

  p_frame_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!status[STAT_VBLANK_BIT] && !status[STAT_VDUE_BIT]));

  p_vint_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[PEND_VINT_BIT] && status[STAT_VDUE_BIT] && vint_en) |-> (irq_level == LVL_VINT));

  p_hint_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == LVL_HINT) |-> (pending[PEND_HINT_BIT] && hint_en));
endmodule

// File: tb/scanline_irq_ctrl_bench.sv
module scanline_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       line_strobe = 1'b0;
  logic       tall_mode = 1'b0;
  logic [7:0] line_reload = 8'd0;
  logic       hint_en = 1'b0;
  logic       vint_en = 1'b0;
  logic       cpu_tick = 1'b0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_level = 3'd0;
  logic [7:0] status;
  logic [7:0] pending;
  logic [2:0] irq_level;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  scanline_irq_ctrl u_scanline_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_strobe(line_strobe),
    .tall_mode(tall_mode), .line_reload(line_reload), .hint_en(hint_en), .vint_en(vint_en),
    .cpu_tick(cpu_tick), .ack_valid(ack_valid), .ack_level(ack_level),
    .status(status), .pending(pending), .irq_level(irq_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk) line_strobe = 1'b1;
    @(negedge clk) line_strobe = 1'b0;
  endtask

  task automatic pulse_ack(input logic [2:0] lvl);
    @(negedge clk) begin ack_valid = 1'b1; ack_level = lvl; end
    @(negedge clk) ack_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) cpu_tick = 1'b1;
      @(negedge clk) cpu_tick = 1'b0;
    end
  endtask

  // opens a frame and runs lines 0..A, checking against a model of R3/R5/R7/R10
  task automatic run_frame(input int n, input bit tall, input bit hen, input bit ven,
                           input bit auto_ack);
    int act_lines = tall ? 240 : 224;
    int cntm = n;
    bit expp = 0;
    bit fire;
    line_reload = 8'(n);
    tall_mode = tall;
    hint_en = hen;
    vint_en = ven;
    pulse_frame();
    chk("R2 vblank cleared", int'(status[3]), 0);
    chk("R2 due cleared", int'(status[7]), 0);
    for (int y = 0; y <= act_lines; y++) begin
      fire = 0;
      if (cntm == 0) begin cntm = n; fire = 1; end
      else cntm--;
      if (fire) expp = 1;
      pulse_line();
      chk($sformatf("R3 hint pending line %0d", y), int'(pending[4]), int'(expp));
      if (expp) chk("R7/R10 level on hint", int'(irq_level), hen ? 4 : 0);
      if (y == act_lines - 1) chk("R5 no vblank before last", int'(status[3]), 0);
      if (y == act_lines) begin
        chk("R5 vblank at line A", int'(status[3]), 1);
        chk("R5 vint pending at line A", int'(pending[5]), 1);
        chk("R6 no due yet", int'(status[7]), 0);
      end
      if (expp && auto_ack) begin
        pulse_ack(3'd4);
        expp = 0;
        chk("R9 ack clears hint", int'(pending[4]), 0);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 status reset", int'(status), 0);
    chk("R1 pending reset", int'(pending), 0);
    chk("R1 level reset", int'(irq_level), 0);
    line_reload = 8'd0;
    pulse_line();
    pulse_line();
    chk("R1 strobe before frame", int'(pending), 0);
  endtask

  task automatic t_lag_enabled();
    run_frame(5, 1'b0, 1'b1, 1'b1, 1'b1);
    ticks(67);
    chk("R6 due not at 67", int'(status[7]), 0);
    chk("R6 no level 6 at 67", int'(irq_level), 0);
    ticks(1);
    chk("R6 due at 68", int'(status[7]), 1);
    chk("R6 level 6 at 68", int'(irq_level), 6);
    pulse_ack(3'd6);
    chk("R9 ack clears vint", int'(pending[5]), 0);
    chk("R9 level falls to 0", int'(irq_level), 0);
  endtask

  task automatic t_tall_blank();
    run_frame(0, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      pulse_line();
      chk("R4 no step in blanking", int'(pending[4]), 0);
    end
    pulse_ack(3'd6);
  endtask

  task automatic t_vint_disabled();
    run_frame(9, 1'b0, 1'b1, 1'b0, 1'b1);
    ticks(68);
    chk("R6 due sets while disabled", int'(status[7]), 1);
    chk("R6 no level when disabled", int'(irq_level), 0);
    pulse_ack(3'd6);
  endtask

  task automatic t_priority();
    // interval 224: the only underflow in a short frame is on line 224
    run_frame(224, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 hint on line A", int'(pending[4]), 1);
    ticks(68);
    chk("R8 level 6 over 4", int'(irq_level), 6);
    pulse_ack(3'd6);
    chk("R9 falls back to 4", int'(irq_level), 4);
    pulse_ack(3'd4);
    chk("R9 falls to 0", int'(irq_level), 0);
    pulse_frame();
    chk("R2 clears due", int'(status[7]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lag_enabled();
    t_tall_blank();
    t_vint_disabled();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule